// File: doc/BRIEF.md
# Glitch-free selectable card clock divider

This block derives the clock driven to a smart card contact from a reference clock. A select input chooses one of two ratios. With select high the card clock runs at half the reference frequency. With select low it runs at the full reference frequency, or at a quarter of it when the build parameter `QUARTER` is set. The select input may change at any time and with no relation to the reference clock. A run enable from the activation sequencer starts and stops the clock. While the enable is low the card clock is held low.

A new select level is passed through a two-stage synchroniser. It must then stay stable for a programmable number of reference periods (ten by default) before it is committed. If the level flips back during that wait, the wait starts again. A committed ratio is switched in only at the end of a complete output period, when the divided clock is low. The output therefore shows no runt high or low phase. Starting gives a complete first high phase, and stopping lets the high phase in progress finish before the output parks low. The pass-through (divide-by-1) path is gated by a latch that is transparent while the reference clock is low, so that path is also clean.

Top module: `ckdiv_top`

## Requirements
- R1: With the committed select high, the card clock has a period of 2 reference periods, with high and low phases of exactly 1 reference period each.
- R2: With the committed select low, the card clock follows the reference clock (high in the reference high half, low in its low half) when `QUARTER`=0. When `QUARTER`=1 the period is 4 reference periods, with high and low phases of 2 reference periods each.
- R3: A select change has no visible effect on the card clock until at least 10 reference periods after the change. The new ratio shows on the output within 22 reference periods.
- R4: A select level that returns to its previous value before the 10-period wait completes is ignored. Each new change restarts the wait, so the 10 periods count from the last change.
- R5: Around a ratio change, no high or low phase of the card clock is shorter than the half-period of the faster of the two ratios.
- R6: After the run enable falls, the high phase in progress finishes at its full length. The card clock then stays low for as long as the enable stays low.
- R7: After the run enable rises, the first card clock activity is a complete high phase of the committed ratio.
- R8: During reset (synchronous, active high), and afterwards while the run enable is low, the card clock is low. The committed select resets to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all registers use its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_async | input | 1 | Ratio select, asynchronous; high = divide by 2, low = divide by 1 (or by 4 when QUARTER=1) |
| run_en | input | 1 | Run enable from the sequencer, synchronous to clk_ref |
| card_clk | output | 1 | Card clock; low while stopped |

## Verification
A select change reaches the committed ratio after two synchroniser edges plus ten settle edges. After that it waits at most one old output period (up to four reference periods) for the boundary. The pass-through path adds one more period, because its gate opens in the reference low half. Starting and stopping likewise wait only for the current period boundary. The bench samples the card clock in the middle of every reference half-period, and judges each result as a run of equal samples. It does not sample at a fixed cycle. Timing checks compare the slot of the first run with the new length against the slot where the stimulus was applied, using bounds of 20 to 44 half-periods. Steady-state checks look only at complete runs, and only once those latency bounds have passed.

// File: rtl/ckdiv_pkg.sv
`timescale 1ns/1ps
package ckdiv_pkg;

    // Division ratios the block can produce
    typedef enum logic [1:0] {
        RATIO_1 = 2'd0,
        RATIO_2 = 2'd1,
        RATIO_4 = 2'd2
    } ratio_e;

    // Enough for the largest ratio (4 reference periods)
    localparam int CNT_W = 2;

    // Sequencer state of the divider
    typedef struct packed {
        logic             run;   // a period is in progress
        ratio_e           mode;  // ratio of the current period
        logic [CNT_W-1:0] cnt;   // reference periods into the current output period
    } phase_t;

    // Registered controls that feed the output gate
    typedef struct packed {
        logic hi;    // divided level (ratios 2 and 4)
        logic pass;  // pass the reference clock through (ratio 1)
    } drive_t;

    // Ratio picked by a select level for the chosen build variant
    function automatic ratio_e ratio_of(input bit quarter, input logic sel);
        if (sel) return RATIO_2;
        return quarter ? RATIO_4 : RATIO_1;
    endfunction

    // Index of the last reference period in one output period
    function automatic logic [CNT_W-1:0] last_cnt(input ratio_e r);
        case (r)
            RATIO_2: return CNT_W'(1);
            RATIO_4: return CNT_W'(3);
            default: return CNT_W'(0);
        endcase
    endfunction

    // Number of reference periods spent high in one output period
    function automatic logic [CNT_W-1:0] half_cnt(input ratio_e r);
        case (r)
            RATIO_2: return CNT_W'(1);
            RATIO_4: return CNT_W'(2);
            default: return CNT_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/ckdiv_sync.sv
`timescale 1ns/1ps
module ckdiv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    // Flop chain for the asynchronous select input
    logic [STAGES-1:0] chain;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("ckdiv_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ckdiv_settle.sv
`timescale 1ns/1ps
module ckdiv_settle #(
    parameter int SETTLE = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_s,
    output logic tgt_sel
);
    localparam int CW = $clog2(SETTLE + 1);

    logic [CW-1:0] wait_q;

    // A differing level must hold for SETTLE edges before it is committed.
    // Returning to the committed level clears the wait.
    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q  <= '0;
            tgt_sel <= 1'b0;
        end else if (sel_s == tgt_sel) begin
            wait_q <= '0;
        end else if (wait_q == CW'(SETTLE - 1)) begin
            tgt_sel <= sel_s;
            wait_q  <= '0;
        end else begin
            wait_q <= wait_q + CW'(1);
        end
    end
endmodule

// File: rtl/ckdiv_phase.sv
`timescale 1ns/1ps
module ckdiv_phase
    import ckdiv_pkg::*;
#(
    parameter bit QUARTER = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   run_en,
    input  logic   tgt_sel,
    output phase_t state,
    output drive_t drv
);
    phase_t cur_q, nxt;
    drive_t drv_q, drv_n;
    ratio_e want;
    logic   boundary;

    always_comb begin
        want     = ratio_of(QUARTER, tgt_sel);
        // End of an output period: idle, every cycle at ratio 1, or the last low cycle
        boundary = !cur_q.run || (cur_q.mode == RATIO_1) ||
                   (cur_q.cnt == last_cnt(cur_q.mode));
        nxt      = cur_q;
        drv_n    = '0;
        if (boundary) begin
            nxt.cnt = '0;
            if (run_en) begin
                nxt.run    = 1'b1;
                nxt.mode   = want;
                drv_n.hi   = (want != RATIO_1);
                drv_n.pass = (want == RATIO_1);
            end else begin
                nxt.run = 1'b0;
            end
        end else begin
            nxt.cnt  = cur_q.cnt + CNT_W'(1);
            drv_n.hi = (nxt.cnt < half_cnt(cur_q.mode));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.run  <= 1'b0;
            cur_q.mode <= RATIO_1;
            cur_q.cnt  <= '0;
            drv_q      <= '0;
        end else begin
            cur_q <= nxt;
            drv_q <= drv_n;
        end
    end

    assign state = cur_q;
    assign drv   = drv_q;
endmodule

// File: rtl/ckdiv_gate.sv
`timescale 1ns/1ps
module ckdiv_gate
    import ckdiv_pkg::*;
(
    input  logic   clk,
    input  drive_t drv,
    output logic   card_clk
);
    logic pass_l;

    // Transparent only while the reference is low, so the enable can
    // never cut a reference high half short.
    always_latch begin
        if (!clk) pass_l = drv.pass;
    end

    assign card_clk = (clk & pass_l) | drv.hi;
endmodule

// File: rtl/ckdiv_top.sv
`timescale 1ns/1ps
module ckdiv_top
    import ckdiv_pkg::*;
#(
    parameter bit QUARTER       = 1'b0,
    parameter int SETTLE_CYCLES = 10,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk_ref,
    input  logic rst,
    input  logic sel_async,
    input  logic run_en,
    output logic card_clk
);
    logic   sel_s;
    logic   tgt_sel;
    phase_t pst;
    drive_t drv;

    ckdiv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk_ref),
        .rst (rst),
        .d   (sel_async),
        .q   (sel_s)
    );

    ckdiv_settle #(.SETTLE(SETTLE_CYCLES)) u_settle (
        .clk     (clk_ref),
        .rst     (rst),
        .sel_s   (sel_s),
        .tgt_sel (tgt_sel)
    );

    ckdiv_phase #(.QUARTER(QUARTER)) u_phase (
        .clk     (clk_ref),
        .rst     (rst),
        .run_en  (run_en),
        .tgt_sel (tgt_sel),
        .state   (pst),
        .drv     (drv)
    );

    ckdiv_gate u_gate (
        .clk      (clk_ref),
        .drv      (drv),
        .card_clk (card_clk)
    );
endmodule

// File: rtl/ckdiv_chk.sv
`timescale 1ns/1ps
module ckdiv_chk
    import ckdiv_pkg::*;
#(
    parameter int SETTLE = 10
) (
    input logic   clk,
    input logic   rst,
    input logic   sel_s,
    input logic   tgt_sel,
    input logic   run,
    input ratio_e mode,
    input logic   hi,
    input logic   pass
);
    localparam int CW = $clog2(SETTLE + 1);

    logic [CW-1:0] diff_run;
    logic [2:0]    hi_run;

    // Edges for which the synchronised select has differed from the committed one
    always_ff @(posedge clk) begin
        if (rst || (sel_s == tgt_sel)) diff_run <= '0;
        else if (diff_run != CW'(SETTLE)) diff_run <= diff_run + CW'(1);
    end

    // Length of the current divided high phase, in reference periods
    always_ff @(posedge clk) begin
        if (rst || !hi)           hi_run <= '0;
        else if (hi_run != 3'd7)  hi_run <= hi_run + 3'd1;
    end

    AST_SETTLE_WAIT: assert property (@(posedge clk) disable iff (rst)
        !$stable(tgt_sel) |-> ($past(diff_run) >= CW'(SETTLE - 1)))
        else $error("committed select changed early"); // R3

    AST_REVERT_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (sel_s == tgt_sel) |=> $stable(tgt_sel))
        else $error("committed select moved without a pending change"); // R4

    AST_SWITCH_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode) |-> !$past(hi))
        else $error("ratio switched while divided clock was high"); // R5

    AST_HALF_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(hi) |-> (hi_run == ((mode == RATIO_4) ? 3'd2 : 3'd1)))
        else $error("divided high phase has wrong length"); // R1 R2

    AST_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(run) |-> !$past(hi))
        else $error("stopped during a high phase"); // R6

    AST_START_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (hi || pass))
        else $error("start did not begin with a high phase"); // R7
endmodule

bind ckdiv_top ckdiv_chk #(.SETTLE(SETTLE_CYCLES)) u_chk (
    .clk     (clk_ref),
    .rst     (rst),
    .sel_s   (sel_s),
    .tgt_sel (tgt_sel),
    .run     (pst.run),
    .mode    (pst.mode),
    .hi      (drv.hi),
    .pass    (drv.pass)
);

// File: tb/sim_ckdiv_top.sv
`timescale 1ns/1ps
module sim_ckdiv_top;
    localparam int MAXS = 8192;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    logic sel0 = 1'b1;
    logic sel1 = 1'b1;
    logic card0, card1;

    int n_tests = 0;
    int n_fail  = 0;
    int slot    = 0;
    bit done    = 1'b0;
    logic rec0 [MAXS];
    logic rec1 [MAXS];

    always #5 clk = ~clk;

    ckdiv_top #(.QUARTER(1'b0)) u0 (
        .clk_ref(clk), .rst(rst), .sel_async(sel0), .run_en(run), .card_clk(card0));
    ckdiv_top #(.QUARTER(1'b1)) u1 (
        .clk_ref(clk), .rst(rst), .sel_async(sel1), .run_en(run), .card_clk(card1));

    // One sample in the middle of each reference half-period
    task automatic put();
        if (slot < MAXS) begin
            rec0[slot] = card0;
            rec1[slot] = card1;
            slot++;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk); #2; put();
            @(negedge clk); #2; put();
        end
    end

    function automatic logic smp(int d, int i);
        return (d == 0) ? rec0[i] : rec1[i];
    endfunction

    // Length of the run starting at s, or -1 if it has not ended yet
    function automatic int run_from(int d, int s);
        int n = 1;
        while (s + n < slot && smp(d, s + n) == smp(d, s)) n++;
        if (s + n >= slot) return -1;
        return n;
    endfunction

    function automatic int first_high(int d, int a, int len);
        for (int s = a + 1; s < slot; s++) begin
            if (smp(d, s) && !smp(d, s - 1) && run_from(d, s) == len) return s;
        end
        return -1;
    endfunction

    function automatic int first_one(int d, int a);
        for (int s = a; s < slot; s++) if (smp(d, s)) return s;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Every complete run in [a,b) must be exp slots long; at least two runs
    task automatic steady(input int d, input int a, input int b, input int exp,
                          input string req);
        int i = a + 1;
        int cnt = 0;
        int bad = -1;
        while (i < b && smp(d, i) == smp(d, i - 1)) i++;
        while (i < b) begin
            int len = run_from(d, i);
            if (len < 0 || i + len > b) break;
            cnt++;
            if (len != exp && bad < 0) bad = len;
            i += len;
        end
        if (cnt < 2) chk(1'b0, req, $sformatf("dut%0d too few runs", d), cnt, 2);
        else chk(bad < 0, req, $sformatf("dut%0d run length", d), bad < 0 ? exp : bad, exp);
    endtask

    function automatic int min_run(int d, int a, int b);
        int i = a + 1;
        int m = 999;
        while (i < b && smp(d, i) == smp(d, i - 1)) i++;
        while (i < b) begin
            int len = run_from(d, i);
            if (len < 0 || i + len > b) break;
            if (len < m) m = len;
            i += len;
        end
        return m;
    endfunction

    function automatic int last_high_len(int d, int a, int b);
        int i = a + 1;
        int l = -1;
        while (i < b && smp(d, i) == smp(d, i - 1)) i++;
        while (i < b) begin
            int len = run_from(d, i);
            if (len < 0 || i + len > b) break;
            if (smp(d, i)) l = len;
            i += len;
        end
        return l;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic latency(input int d, input int c, input int len, input string req);
        int s = first_high(d, c, len);
        chk(s >= 0 && (s - c) >= 20 && (s - c) <= 44, req,
            $sformatf("dut%0d switch latency (half-periods)", d), s < 0 ? -1 : s - c, 20);
    endtask

    initial begin
        int c, c2, r, s, f;
        // R8: reset and idle keep the clock low
        cyc(5);
        rst = 1'b0;
        cyc(20);
        for (int d = 0; d < 2; d++) begin
            f = first_one(d, 0);
            chk(f < 0, "R8", $sformatf("dut%0d low in reset/idle", d), f, -1);
        end

        // R7 and R1: start at divide-by-2
        r = slot; run = 1'b1; cyc(30);
        for (int d = 0; d < 2; d++) begin
            f = first_one(d, r);
            chk(f >= 0 && run_from(d, f) == 2, "R7",
                $sformatf("dut%0d first high length", d), f < 0 ? -1 : run_from(d, f), 2);
            steady(d, r + 12, slot, 2, "R1");
        end

        // R3, R5, R2: switch to the low-select ratio
        c = slot; sel0 = 1'b0; sel1 = 1'b0; cyc(40);
        latency(0, c, 1, "R3");
        latency(1, c, 4, "R3");
        chk(min_run(0, c, slot) >= 1, "R5", "dut0 shortest phase", min_run(0, c, slot), 1);
        chk(min_run(1, c, slot) >= 2, "R5", "dut1 shortest phase", min_run(1, c, slot), 2);
        cyc(20);
        steady(0, c + 60, slot, 1, "R2");
        steady(1, c + 60, slot, 4, "R2");

        // R3, R5, R1: switch back to divide-by-2
        c = slot; sel0 = 1'b1; sel1 = 1'b1; cyc(40);
        latency(0, c, 2, "R3");
        latency(1, c, 2, "R3");
        chk(min_run(0, c, slot) >= 1, "R5", "dut0 shortest phase", min_run(0, c, slot), 1);
        chk(min_run(1, c, slot) >= 2, "R5", "dut1 shortest phase", min_run(1, c, slot), 2);
        cyc(20);
        steady(0, c + 60, slot, 2, "R1");
        steady(1, c + 60, slot, 2, "R1");

        // R4: a 5-period select pulse is ignored
        c = slot; sel0 = 1'b0; sel1 = 1'b0; cyc(5);
        sel0 = 1'b1; sel1 = 1'b1; cyc(40);
        steady(0, c - 20, slot, 2, "R4");
        steady(1, c - 20, slot, 2, "R4");

        // R4: the wait restarts on every change
        sel0 = 1'b0; sel1 = 1'b0; cyc(7);
        sel0 = 1'b1; sel1 = 1'b1; cyc(3);
        c2 = slot; sel0 = 1'b0; sel1 = 1'b0; cyc(40);
        for (int d = 0; d < 2; d++) begin
            s = first_high(d, c2 - 30, (d == 0) ? 1 : 4);
            chk(s >= 0 && (s - c2) >= 20, "R4",
                $sformatf("dut%0d change after restart (half-periods)", d), s < 0 ? -1 : s - c2, 20);
        end

        // R6: stop, last high phase complete, then held low
        s = slot; run = 1'b0; cyc(30);
        for (int d = 0; d < 2; d++) begin
            f = first_one(d, s + 12);
            chk(f < 0, "R6", $sformatf("dut%0d held low after stop", d), f, -1);
            chk(last_high_len(d, s - 20, slot) == ((d == 0) ? 1 : 4), "R6",
                $sformatf("dut%0d final high length", d), last_high_len(d, s - 20, slot),
                (d == 0) ? 1 : 4);
        end

        // R7: restart in the low-select ratio
        r = slot; run = 1'b1; cyc(30);
        for (int d = 0; d < 2; d++) begin
            f = first_one(d, r);
            chk(f >= 0 && run_from(d, f) == ((d == 0) ? 1 : 4), "R7",
                $sformatf("dut%0d first high length", d), f < 0 ? -1 : run_from(d, f),
                (d == 0) ? 1 : 4);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule